// File: doc/BRIEF.md
# DVFS Load-Level Register Controller

This block keeps the operating point of a processor for four load levels and presents the clock and voltage selections for the level that is in force. Level 0 is the fastest level. Each level carries a 3-bit clock divider, a 1-bit clock-source select, a 2-bit PLL-source select and a 2-bit supply select. Software reaches the storage through a small register bus that has a single request per cycle and combinational read data. The bus has two packed configuration words, each holding two levels, a load-select word and a dynamic-mode word. The clock generator, the divider circuit and the regulator lie outside the block. It only drives the codes they consume.

A two-state mode machine sets the behaviour. In MODE_STATIC the outputs show level 0 and all registers accept writes. The transition ENABLE is a write to the dynamic-mode word with bit 31 set, made while in MODE_STATIC. The transition DISABLE is a write to that word with bit 31 clear, made while in MODE_DYNAMIC. Any other cycle is HOLD. In MODE_DYNAMIC the configuration and load-select words are frozen. Each output field takes the selected level's value when its own enable bit is set, and the level-0 value when it is not. Saved state is therefore restored in this order: configuration words, then load select, then the dynamic-mode word.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset all registers read zero, the mode is MODE_STATIC, all output codes and `active_level` are zero and `level_changed` is low.
- R2: Offset 0x18 holds level 0 in bits 31:16 and level 1 in bits 15:0. Offset 0x1C holds level 2 in bits 31:16 and level 3 in bits 15:0. Within each 16-bit slot the divider is at bits 15:13, the clock-source select at bit 11, the PLL-source select at bits 10:9 and the supply select at bits 7:6. All other slot bits read zero.
- R3: Offset 0x24 reads back the master enable at bit 31, the supply enable at bit 30, the divider enable at bit 29, the PLL-source enable at bit 28 and the clock-select enable at bit 26. Its other bits read zero. This word is writable in both modes.
- R4: Offset 0x30 holds the requested level in bits 1:0, and its other bits read zero.
- R5: While the master enable is set, writes to 0x18, 0x1C and 0x30 leave their contents unchanged. After the master enable is cleared those writes take effect again.
- R6: With the master enable clear, `active_level` is 0 and every output code equals the level-0 field.
- R7: With the master enable set, `active_level` equals the load select. Each output code comes from that level when its enable bit is set (divider: bit 29, clock source: bit 26, PLL source: bit 28, supply: bit 30) and from level 0 otherwise.
- R8: A register write stored at a clock edge changes the outputs at the following edge, not at the same one.
- R9: `level_changed` is high for exactly the one cycle in which `active_level` takes a value that differs from its previous value.
- R10: Reads of any other offset return zero, and writes to them change no register or output.
- R11: Writing saved contents back after a reset, in the order configuration words, load select, dynamic-mode word, reproduces the saved read-back values and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current read request, zero otherwise |
| div_sel | output | 3 | Active clock divider code |
| clk_src_sel | output | 1 | Active clock-source select |
| pll_sel | output | 2 | Active PLL-source select |
| vdd_sel | output | 2 | Active supply select |
| active_level | output | 2 | Load level in force |
| level_changed | output | 1 | One-cycle pulse when the level in force changes |

## Verification
Directed patterns come first. One writes distinct configurations to level 0 and level 2 and then turns on one field enable at a time, which shows whether each output field is steered by its own enable bit and not by a shared one. Writes made with the master enable set, writes to offsets next to the mapped ones, and a save-reset-restore sequence separate lock and decode faults from storage faults. A long run of random writes and reads, with the master bit random, then mixes mode changes with level changes and checks the one-cycle output delay and the change pulse on every write.

// File: rtl/dvfs_ctrl_pkg.sv
package dvfs_ctrl_pkg;

    parameter int NUM_LEVELS = 4;
    parameter int NUM_PAIRS  = NUM_LEVELS / 2;
    parameter int LVL_W      = $clog2(NUM_LEVELS);
    parameter int DATA_W     = 32;
    parameter int SLOT_W     = DATA_W / 2;
    parameter int DIV_W      = 3;
    parameter int PLL_W      = 2;
    parameter int VSEL_W     = 2;

    // Field positions inside one 16-bit level slot
    parameter int DIV_LSB  = 13;
    parameter int CSRC_BIT = 11;
    parameter int PLL_LSB  = 9;
    parameter int VSEL_LSB = 6;

    // Bit positions in the dynamic-mode word
    parameter int CSEL_EN_BIT = 26;
    parameter int SRC_EN_BIT  = 28;
    parameter int DIV_EN_BIT  = 29;
    parameter int VDD_EN_BIT  = 30;
    parameter int MASTER_BIT  = 31;

    // Register offsets
    parameter int CFG_BASE  = 'h18;
    parameter int ADDR_DYN  = 'h24;
    parameter int ADDR_LOAD = 'h30;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              csrc;
        logic [PLL_W-1:0]  pll;
        logic [VSEL_W-1:0] vsel;
    } lvl_cfg_t;

    typedef struct packed {
        logic vdd;
        logic div;
        logic src;
        logic csel;
    } en_set_t;

    typedef enum logic {
        MODE_STATIC  = 1'b0,
        MODE_DYNAMIC = 1'b1
    } mode_t;

    function automatic lvl_cfg_t slot_unpack(input logic [SLOT_W-1:0] s);
        lvl_cfg_t c;
        c.div  = s[DIV_LSB +: DIV_W];
        c.csrc = s[CSRC_BIT];
        c.pll  = s[PLL_LSB +: PLL_W];
        c.vsel = s[VSEL_LSB +: VSEL_W];
        return c;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_pack(input lvl_cfg_t c);
        logic [SLOT_W-1:0] s;
        s = '0;
        s[DIV_LSB +: DIV_W]   = c.div;
        s[CSRC_BIT]           = c.csrc;
        s[PLL_LSB +: PLL_W]   = c.pll;
        s[VSEL_LSB +: VSEL_W] = c.vsel;
        return s;
    endfunction

endpackage

// File: rtl/dvfs_ctrl_mode_fsm.sv
module dvfs_ctrl_mode_fsm
    import dvfs_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dyn_wr,
    input  logic master_req,
    output logic dyn_on
);

    mode_t state_q;
    mode_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_STATIC;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_STATIC: begin
                if (dyn_wr && master_req) begin
                    state_d = MODE_DYNAMIC;
                end
            end
            MODE_DYNAMIC: begin
                if (dyn_wr && !master_req) begin
                    state_d = MODE_STATIC;
                end
            end
            default: state_d = MODE_STATIC;
        endcase
    end

    always_comb begin
        dyn_on = (state_q == MODE_DYNAMIC);
    end

endmodule

// File: rtl/dvfs_ctrl_regs.sv
module dvfs_ctrl_regs
    import dvfs_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dyn_on,
    output lvl_cfg_t          cfg_q [NUM_LEVELS],
    output en_set_t           en_q,
    output logic [LVL_W-1:0]  load_q,
    output logic              dyn_wr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] DYN_A  = ADDR_W'(ADDR_DYN);
    localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(ADDR_LOAD);

    logic wr;
    logic rd;

    always_comb begin
        wr     = req_valid && req_write;
        rd     = req_valid && !req_write;
        dyn_wr = wr && (req_addr == DYN_A);
    end

    // One storage slot per level; even levels sit in the upper half-word
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        localparam int                SLOT_LSB = (g % 2 == 0) ? SLOT_W : 0;
        localparam logic [ADDR_W-1:0] MY_ADDR  = ADDR_W'(CFG_BASE + 4 * (g / 2));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr && !dyn_on && (req_addr == MY_ADDR)) begin
                cfg_q[g] <= slot_unpack(req_wdata[SLOT_LSB +: SLOT_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (dyn_wr) begin
            en_q.vdd  <= req_wdata[VDD_EN_BIT];
            en_q.div  <= req_wdata[DIV_EN_BIT];
            en_q.src  <= req_wdata[SRC_EN_BIT];
            en_q.csel <= req_wdata[CSEL_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr && !dyn_on && (req_addr == LOAD_A)) begin
            load_q <= req_wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (req_addr == ADDR_W'(CFG_BASE + 4 * p)) begin
                    rd_data = {slot_pack(cfg_q[2*p]), slot_pack(cfg_q[2*p+1])};
                end
            end
            if (req_addr == DYN_A) begin
                rd_data[MASTER_BIT]  = dyn_on;
                rd_data[VDD_EN_BIT]  = en_q.vdd;
                rd_data[DIV_EN_BIT]  = en_q.div;
                rd_data[SRC_EN_BIT]  = en_q.src;
                rd_data[CSEL_EN_BIT] = en_q.csel;
            end
            if (req_addr == LOAD_A) begin
                rd_data[LVL_W-1:0] = load_q;
            end
        end
    end

endmodule

// File: rtl/dvfs_ctrl_outsel.sv
module dvfs_ctrl_outsel
    import dvfs_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lvl_cfg_t         cfg_q [NUM_LEVELS],
    input  en_set_t          en_q,
    input  logic             dyn_on,
    input  logic [LVL_W-1:0] load_q,
    output lvl_cfg_t         out_q,
    output logic [LVL_W-1:0] act_q,
    output logic             chg_q
);

    logic [LVL_W-1:0] act_d;
    lvl_cfg_t         sel;
    lvl_cfg_t         out_d;

    always_comb begin
        act_d = dyn_on ? load_q : '0;
        sel   = cfg_q[act_d];
        out_d = cfg_q[0];
        if (dyn_on && en_q.div)  out_d.div  = sel.div;
        if (dyn_on && en_q.csel) out_d.csrc = sel.csrc;
        if (dyn_on && en_q.src)  out_d.pll  = sel.pll;
        if (dyn_on && en_q.vdd)  out_d.vsel = sel.vsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            act_q <= '0;
            chg_q <= 1'b0;
        end else begin
            out_q <= out_d;
            act_q <= act_d;
            chg_q <= (act_d != act_q);
        end
    end

endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
    import dvfs_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_sel,
    output logic              clk_src_sel,
    output logic [PLL_W-1:0]  pll_sel,
    output logic [VSEL_W-1:0] vdd_sel,
    output logic [LVL_W-1:0]  active_level,
    output logic              level_changed
);

    lvl_cfg_t         cfg_q [NUM_LEVELS];
    en_set_t          en_q;
    logic [LVL_W-1:0] load_q;
    logic             dyn_wr;
    logic             dyn_on;
    lvl_cfg_t         out_q;

    dvfs_ctrl_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dyn_on    (dyn_on),
        .cfg_q     (cfg_q),
        .en_q      (en_q),
        .load_q    (load_q),
        .dyn_wr    (dyn_wr),
        .rd_data   (rd_data)
    );

    dvfs_ctrl_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dyn_wr     (dyn_wr),
        .master_req (req_wdata[MASTER_BIT]),
        .dyn_on     (dyn_on)
    );

    dvfs_ctrl_outsel u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_q  (cfg_q),
        .en_q   (en_q),
        .dyn_on (dyn_on),
        .load_q (load_q),
        .out_q  (out_q),
        .act_q  (active_level),
        .chg_q  (level_changed)
    );

    always_comb begin
        div_sel     = out_q.div;
        clk_src_sel = out_q.csrc;
        pll_sel     = out_q.pll;
        vdd_sel     = out_q.vsel;
    end

endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk
    import dvfs_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rd_data,
    input lvl_cfg_t          cfg_q [NUM_LEVELS],
    input en_set_t           en_q,
    input logic              dyn_on,
    input logic [LVL_W-1:0]  load_q,
    input logic [DIV_W-1:0]  div_sel,
    input logic [VSEL_W-1:0] vdd_sel,
    input logic [LVL_W-1:0]  active_level,
    input logic              level_changed
);

    logic cfg_hit;
    logic mapped;

    always_comb begin
        cfg_hit = (req_addr == ADDR_W'('h18)) || (req_addr == ADDR_W'('h1C));
        mapped  = cfg_hit || (req_addr == ADDR_W'('h24)) || (req_addr == ADDR_W'('h30));
    end

    // R5
    load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && dyn_on && (req_addr == ADDR_W'('h30))) |=> $stable(load_q));

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lock
        // R5
        cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && dyn_on && cfg_hit) |=> $stable(cfg_q[g]));
    end

    // R6
    static_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dyn_on |=> (div_sel == $past(cfg_q[0].div)) && (active_level == '0));

    // R6
    static_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dyn_on |=> (vdd_sel == $past(cfg_q[0].vsel)));

    // R7
    dyn_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_on && en_q.div) |=> (div_sel == $past(cfg_q[load_q].div)));

    // R7
    dyn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_on |=> (active_level == $past(load_q)));

    // R9
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_changed |-> (active_level != $past(active_level)));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !mapped) |-> (rd_data == '0));

endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .rd_data       (rd_data),
    .cfg_q         (cfg_q),
    .en_q          (en_q),
    .dyn_on        (dyn_on),
    .load_q        (load_q),
    .div_sel       (div_sel),
    .vdd_sel       (vdd_sel),
    .active_level  (active_level),
    .level_changed (level_changed)
);

// File: tb/dvfs_level_ctrl_bench.sv
module dvfs_level_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [2:0]  div_sel;
    logic        clk_src_sel;
    logic [1:0]  pll_sel;
    logic [1:0]  vdd_sel;
    logic [1:0]  active_level;
    logic        level_changed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvfs_level_ctrl u_dvfs_level_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rd_data       (rd_data),
        .div_sel       (div_sel),
        .clk_src_sel   (clk_src_sel),
        .pll_sel       (pll_sel),
        .vdd_sel       (vdd_sel),
        .active_level  (active_level),
        .level_changed (level_changed)
    );

    // Reference model of the register contents
    logic [2:0] m_div  [4];
    logic       m_csrc [4];
    logic [1:0] m_pll  [4];
    logic [1:0] m_vsel [4];
    logic       m_master, m_vdd_en, m_div_en, m_src_en, m_csel_en;
    logic [1:0] m_load;

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_div[i] = '0; m_csrc[i] = 1'b0; m_pll[i] = '0; m_vsel[i] = '0;
        end
        m_master = 0; m_vdd_en = 0; m_div_en = 0; m_src_en = 0; m_csel_en = 0;
        m_load = '0;
    endtask

    task automatic set_slot(input int i, input logic [15:0] s);
        m_div[i] = s[15:13]; m_csrc[i] = s[11]; m_pll[i] = s[10:9]; m_vsel[i] = s[7:6];
    endtask

    function automatic logic [15:0] get_slot(input int i);
        return {m_div[i], 1'b0, m_csrc[i], m_pll[i], 1'b0, m_vsel[i], 6'b0};
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h18: if (!m_master) begin set_slot(0, d[31:16]); set_slot(1, d[15:0]); end
            8'h1C: if (!m_master) begin set_slot(2, d[31:16]); set_slot(3, d[15:0]); end
            8'h24: begin
                m_master = d[31]; m_vdd_en = d[30]; m_div_en = d[29];
                m_src_en = d[28]; m_csel_en = d[26];
            end
            8'h30: if (!m_master) m_load = d[1:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h18: return {get_slot(0), get_slot(1)};
            8'h1C: return {get_slot(2), get_slot(3)};
            8'h24: return {m_master, m_vdd_en, m_div_en, m_src_en, 1'b0, m_csel_en, 26'b0};
            8'h30: return {30'b0, m_load};
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] exp_act();
        return m_master ? m_load : 2'd0;
    endfunction

    // Packing: {active, div, csrc, pll, vsel}
    function automatic logic [31:0] exp_outs();
        logic [1:0] l;
        l = exp_act();
        return {22'b0, l,
                (m_master && m_div_en)  ? m_div[l]  : m_div[0],
                (m_master && m_csel_en) ? m_csrc[l] : m_csrc[0],
                (m_master && m_src_en)  ? m_pll[l]  : m_pll[0],
                (m_master && m_vdd_en)  ? m_vsel[l] : m_vsel[0]};
    endfunction

    function automatic logic [31:0] dut_outs();
        return {22'b0, active_level, div_sel, clk_src_sel, pll_sel, vdd_sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input string req, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] old_o;
        logic [1:0]  old_a;
        old_o = exp_outs();
        old_a = exp_act();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        // R8: stored at this edge, outputs not yet moved
        chk("R8 outputs one edge after store", dut_outs(), old_o);
        model_write(a, d);
        @(negedge clk);
        chk(req, dut_outs(), exp_outs());
        chk("R9 change pulse", {31'b0, level_changed}, {31'b0, exp_act() != old_a});
        @(negedge clk);
        chk("R9 pulse lasts one cycle", {31'b0, level_changed}, 32'd0);
    endtask

    task automatic do_read(input string req, input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        chk(req, rd_data, exp_read(a));
        req_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] s18, s1c, s24, s30, so;
        logic [7:0]  addrs [5];
        int          seed;
        seed = $urandom(32'h1d2c3b4a);
        addrs[0] = 8'h18; addrs[1] = 8'h1C; addrs[2] = 8'h24; addrs[3] = 8'h30; addrs[4] = 8'h00;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs after reset", dut_outs(), 32'd0);
        chk("R1 no pulse after reset", {31'b0, level_changed}, 32'd0);
        do_read("R1 reset 0x18", 8'h18);
        do_read("R1 reset 0x1C", 8'h1C);
        do_read("R1 reset 0x24", 8'h24);
        do_read("R1 reset 0x30", 8'h30);

        // R2 slot packing and masking of unused bits
        do_write("R6 static after cfg write", 8'h18, 32'hFFFF_FFFF);
        do_read("R2 unused slot bits read zero", 8'h18);
        do_write("R6 static level0 fields", 8'h18, 32'h2200_C8C0);
        do_read("R2 level0/level1 slots", 8'h18);
        do_write("R6 static level0 fields", 8'h1C, 32'hAD80_6A40);
        do_read("R2 level2/level3 slots", 8'h1C);

        // R4 load select, R6 no effect while static
        do_write("R6 load ignored while static", 8'h30, 32'hFFFF_FFFE);
        do_read("R4 load select low bits", 8'h30);

        // R7 each field enable alone (level 2 selected)
        do_write("R7 divider enable only", 8'h24, 32'hA000_0000);
        do_read("R3 dynamic word readback", 8'h24);
        do_write("R7 disable", 8'h24, 32'h0000_0000);
        do_write("R7 clock-select enable only", 8'h24, 32'h8400_0000);
        do_write("R7 disable", 8'h24, 32'h0000_0000);
        do_write("R7 pll-source enable only", 8'h24, 32'h9000_0000);
        do_write("R7 disable", 8'h24, 32'h0000_0000);
        do_write("R7 supply enable only", 8'h24, 32'hC000_0000);
        do_write("R7 all enables", 8'h24, 32'hFFFF_FFFF);
        do_read("R3 unused dynamic bits read zero", 8'h24);

        // R5 locked writes
        do_write("R5 cfg write locked", 8'h18, 32'h1234_5678);
        do_read("R5 0x18 unchanged", 8'h18);
        do_write("R5 cfg write locked", 8'h1C, 32'h0000_0000);
        do_read("R5 0x1C unchanged", 8'h1C);
        do_write("R5 load write locked", 8'h30, 32'h0000_0001);
        do_read("R5 0x30 unchanged", 8'h30);
        do_write("R6 disable returns to level0", 8'h24, 32'h7400_0000);
        do_write("R5 load writable again", 8'h30, 32'h0000_0003);
        do_read("R5 0x30 updated", 8'h30);

        // R10 unmapped offsets
        do_write("R10 unmapped write", 8'h20, 32'hFFFF_FFFF);
        do_write("R10 unmapped write", 8'h19, 32'hFFFF_FFFF);
        do_write("R10 unmapped write", 8'h34, 32'h8000_0000);
        do_read("R10 unmapped read", 8'h20);
        do_read("R10 unmapped read", 8'h31);
        do_read("R10 0x18 untouched", 8'h18);

        // R11 save, reset, restore in order
        do_write("R7 enable level3", 8'h24, 32'hF400_0000);
        do_read("R11 save", 8'h18); s18 = rd_data;
        do_read("R11 save", 8'h1C); s1c = rd_data;
        do_read("R11 save", 8'h24); s24 = rd_data;
        do_read("R11 save", 8'h30); s30 = rd_data;
        so = dut_outs();
        pulse_reset();
        chk("R1 outputs after mid-run reset", dut_outs(), 32'd0);
        do_write("R11 restore cfg", 8'h18, s18);
        do_write("R11 restore cfg", 8'h1C, s1c);
        do_write("R11 restore load", 8'h30, s30);
        do_write("R11 restore mode last", 8'h24, s24);
        do_read("R11 restored 0x18", 8'h18);
        do_read("R11 restored 0x24", 8'h24);
        chk("R11 restored outputs", dut_outs(), so);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          k;
            k = $urandom % 5;
            a = (k == 4) ? 8'($urandom) : addrs[k];
            d = $urandom;
            do_write("R7 random outputs", a, d);
            k = $urandom % 5;
            a = (k == 4) ? 8'($urandom) : addrs[k];
            do_read("R2 random readback", a);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule